// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the module clock. Two divide laws share one control word. The linear law divides by 2×(N2+1), where N2 is an 8-bit field. The power-of-two law divides by 2^N1, where N1 is a 4-bit field. A select input chooses the law. In the control word the linear field is bits 7:0, the exponent field is bits 11:8 and the select is bit 12. These reach the block as three separate ports: `lin_div`, `exp_div` and `law_sel`.

The transfer engine raises `en` for the length of a transfer and lowers it at the end. While `en` is low the serial clock rests at the level given by `cpol`. When `en` is sampled high, the divider captures the fields and `cpol`, and it makes its first edge one half period later. For every half period it pulses either a leading-edge strobe or a trailing-edge strobe, and the shifter uses these strobes to launch and capture bits. Computing divider values from a target rate is left to software.

Top module: `spi_dual_clkdiv`

## Requirements
- R1: While `en` is low, `sclk` equals `cpol` from the cycle after `en` is sampled low, and both strobes are 0.
- R2: With `law_sel`=1, `sclk` changes level every N2+1 module clock cycles, which gives a period of 2×(N2+1) cycles. N2=0 gives divide-by-2.
- R3: With `law_sel`=0 and N1 from 1 to 15, `sclk` changes level every 2^(N1-1) cycles, which gives a period of 2^N1 cycles.
- R4: With `law_sel`=0 and N1=0, `sclk` equals `cpol` XOR the module clock. Both strobes are then held at 1 in every cycle of the transfer.
- R5: The first level change comes exactly H cycles after the clock edge at which `en` is first sampled high, where H is the half period of R2 or R3.
- R6: Outside the N1=0 case, the strobes never coincide and they alternate, beginning with the leading strobe. The leading strobe is high in the single cycle after `sclk` moves to NOT `cpol`. The trailing strobe is high in the single cycle after `sclk` returns to `cpol`. So with `cpol`=0 the leading edge is a rising edge, and with `cpol`=1 it is a falling edge.
- R7: The divider fields, `law_sel` and `cpol` are captured only at transfer start. Changing them while `en` stays high does not alter the running half period.
- R8: Lowering `en` stops the clock at once, with no further edge. Raising `en` again starts a fresh transfer with a full first half period.
- R9: During synchronous reset, `sclk` equals `cpol` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transfer active, from the transfer engine |
| lin_div | input | 8 | Linear divider field N2 (control bits 7:0) |
| exp_div | input | 4 | Power-of-two divider field N1 (control bits 11:8) |
| law_sel | input | 1 | 1 selects the linear law, 0 selects the power-of-two law (control bit 12) |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | Single-cycle strobe after each leading edge |
| trail_stb | output | 1 | Single-cycle strobe after each trailing edge |

## Verification
The level checks compare `sclk` with the live `cpol` input. They therefore assume that `cpol` is held steady for as long as `en` is high. The bench changes `cpol` only while `en` is low, or in the same cycle that `en` rises. The clocked checks are switched off in the N1=0 pass-through case, because there `sclk` follows the module clock itself and cannot be sampled on that clock. The bench checks that case separately, with samples taken in the high and low halves of the clock cycle.

// File: rtl/spi_cdiv_pkg.sv
package spi_cdiv_pkg;

    localparam int DEF_LIN_W = 8;
    localparam int DEF_EXP_W = 4;

    typedef enum logic {
        LAW_POW2 = 1'b0,
        LAW_LIN  = 1'b1
    } law_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } stb_t;

    // Counter width: enough for a linear half period minus one, and for 2^(2^EXP_W - 2).
    function automatic int cnt_width(int lin_w, int exp_w);
        int pw;
        pw = (1 << exp_w) - 1;
        return (lin_w + 1 > pw) ? lin_w + 1 : pw;
    endfunction

endpackage

// File: rtl/spi_cdiv_cfg.sv
module spi_cdiv_cfg
    import spi_cdiv_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W,
    parameter int CNT_W = cnt_width(DEF_LIN_W, DEF_EXP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] exp_div,
    input  law_e             law,
    input  logic             cpol,
    output logic [CNT_W-1:0] half_m1_nxt,
    output logic [CNT_W-1:0] half_m1,
    output logic             bypass,
    output logic             cpol_q
);

    localparam logic [EXP_W-1:0] EXP_ONE = {{(EXP_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [EXP_W-1:0] shamt;
    logic             bypass_nxt;

    always_comb begin
        shamt       = exp_div - EXP_ONE;
        bypass_nxt  = 1'b0;
        half_m1_nxt = '0;
        if (law == LAW_LIN) begin
            half_m1_nxt = CNT_W'(lin_div);
        end else if (exp_div == '0) begin
            bypass_nxt  = 1'b1;
        end else begin
            half_m1_nxt = (CNT_ONE << shamt) - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_m1 <= '0;
            bypass  <= 1'b0;
            cpol_q  <= 1'b0;
        end else if (start) begin
            half_m1 <= half_m1_nxt;
            bypass  <= bypass_nxt;
            cpol_q  <= cpol;
        end
    end

endmodule

// File: rtl/spi_cdiv_timer.sv
module spi_cdiv_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_val;
        end else if (run) begin
            if (cnt == '0) cnt <= reload_val;
            else           cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/spi_cdiv_edge.sv
module spi_cdiv_edge
    import spi_cdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic phase,
    output stb_t stb
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= 1'b0;
            stb   <= '0;
        end else begin
            stb.lead  <= tick && !phase;
            stb.trail <= tick && phase;
            if (tick) phase <= !phase;
        end
    end

endmodule

// File: rtl/spi_dual_clkdiv.sv
module spi_dual_clkdiv
    import spi_cdiv_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W,
    parameter int EXP_W = DEF_EXP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] exp_div,
    input  logic             law_sel,
    input  logic             cpol,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);

    localparam int CNT_W = cnt_width(LIN_W, EXP_W);

    logic             active_q;
    logic             start;
    logic             run;
    logic             tick;
    logic             phase;
    logic             bypass;
    logic             cpol_q;
    logic             byp_act;
    logic [CNT_W-1:0] half_m1_nxt;
    logic [CNT_W-1:0] half_m1;
    law_e             law;
    stb_t             stb;

    assign law     = law_e'(law_sel);
    assign start   = en && !active_q;
    assign run     = en && active_q && !bypass;
    assign byp_act = active_q && bypass;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= en;
    end

    spi_cdiv_cfg #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .lin_div     (lin_div),
        .exp_div     (exp_div),
        .law         (law),
        .cpol        (cpol),
        .half_m1_nxt (half_m1_nxt),
        .half_m1     (half_m1),
        .bypass      (bypass),
        .cpol_q      (cpol_q)
    );

    spi_cdiv_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .start      (start),
        .run        (run),
        .load_val   (half_m1_nxt),
        .reload_val (half_m1),
        .tick       (tick)
    );

    spi_cdiv_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .tick  (tick),
        .phase (phase),
        .stb   (stb)
    );

    always_comb begin
        if (!active_q)    sclk = cpol;
        else if (bypass)  sclk = cpol_q ^ clk;
        else              sclk = cpol_q ^ phase;
    end

    assign lead_stb  = byp_act || stb.lead;
    assign trail_stb = byp_act || stb.trail;

endmodule

// File: rtl/spi_cdiv_chk.sv
module spi_cdiv_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cpol,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb,
    input logic byp_act
);

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sclk == cpol));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!lead_stb && !trail_stb));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !byp_act |-> $onehot0({lead_stb, trail_stb}));

    // R6
    lead_level_chk: assert property (@(posedge clk) disable iff (rst)
        (lead_stb && !byp_act) |-> (sclk != cpol));

    // R6
    trail_level_chk: assert property (@(posedge clk) disable iff (rst)
        (trail_stb && !byp_act) |-> (sclk == cpol));

    // R6
    lead_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (lead_stb && !byp_act) |=> !lead_stb);

endmodule

bind spi_dual_clkdiv spi_cdiv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cpol      (cpol),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .byp_act   (byp_act)
);

// File: tb/tb_spi_dual_clkdiv.sv
module tb_spi_dual_clkdiv;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] lin_div = '0;
    logic [3:0] exp_div = '0;
    logic       law_sel = 1'b0;
    logic       cpol = 1'b0;
    logic       sclk, lead_stb, trail_stb;

    int  checks = 0;
    int  failures = 0;
    int  cyc = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        int    at;
        bit    lead;
        bit    lvl;
        string req;
    } exp_t;

    exp_t sb[$];

    spi_dual_clkdiv dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .lin_div   (lin_div),
        .exp_div   (exp_div),
        .law_sel   (law_sel),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops one expected edge per observed strobe
    always @(negedge clk) begin
        if (mon_en && !rst && (lead_stb || trail_stb)) begin
            if (sb.size() == 0) begin
                chk("R8", 1, 0, "unexpected strobe");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, cyc, e.at, "strobe cycle");
                chk("R6", int'(lead_stb), int'(e.lead), "lead strobe");
                chk("R6", int'(trail_stb), int'(!e.lead), "trail strobe");
                chk(e.req, int'(sclk), int'(e.lvl), "sclk level");
            end
        end
    end

    task automatic check_idle(input string req);
        chk(req, int'(sclk), int'(cpol), "idle sclk");
        chk(req, int'(lead_stb), 0, "idle lead");
        chk(req, int'(trail_stb), 0, "idle trail");
    endtask

    // Driver: one transfer of nedge edges, expected edges queued up front
    task automatic xfer(input bit lin, input logic [7:0] n2, input logic [3:0] n1,
                        input bit cp, input int nedge, input bit mutate, input string req);
        int h;
        int c0;
        @(negedge clk);
        law_sel = lin;
        lin_div = n2;
        exp_div = n1;
        cpol    = cp;
        en      = 1'b1;
        c0      = cyc + 1;
        h       = lin ? (int'(n2) + 1) : (1 << (int'(n1) - 1));
        for (int k = 1; k <= nedge; k++) begin
            exp_t e;
            e.at   = c0 + k * h;
            e.lead = (k % 2) == 1;
            e.lvl  = e.lead ? !cp : cp;
            e.req  = (k == 1) ? "R5" : req;
            sb.push_back(e);
        end
        if (mutate) begin
            @(negedge clk);
            lin_div = 8'd9;
            law_sel = !lin;
            exp_div = 4'd2;
        end
        while (cyc != c0 + nedge * h) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk(req, sb.size(), 0, "edges left in queue");
        check_idle("R8");
    endtask

    task automatic bypass_run(input bit cp);
        mon_en = 1'b0;
        @(negedge clk);
        law_sel = 1'b0;
        exp_div = 4'd0;
        cpol    = cp;
        en      = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4", int'(lead_stb), 1, "bypass lead");
        chk("R4", int'(trail_stb), 1, "bypass trail");
        chk("R4", int'(sclk), int'(cp), "bypass sclk, clk low");
        @(posedge clk);
        #1;
        chk("R4", int'(sclk), int'(!cp), "bypass sclk, clk high");
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1");
        mon_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R9");
        cpol = 1'b1;
        @(negedge clk);
        chk("R9", int'(sclk), 1, "reset sclk, cpol=1");
        rst = 1'b0;
        cpol = 1'b0;
        mon_en = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1");

        xfer(1'b1, 8'd0,   4'd0,  1'b0, 6, 1'b0, "R2");
        xfer(1'b1, 8'd3,   4'd0,  1'b1, 4, 1'b0, "R2");
        @(negedge clk);
        check_idle("R1");
        xfer(1'b1, 8'd255, 4'd0,  1'b0, 2, 1'b0, "R2");
        xfer(1'b0, 8'd0,   4'd1,  1'b1, 5, 1'b0, "R3");
        xfer(1'b0, 8'd0,   4'd3,  1'b0, 4, 1'b0, "R3");
        xfer(1'b0, 8'd0,   4'd15, 1'b0, 2, 1'b0, "R3");
        xfer(1'b1, 8'd2,   4'd0,  1'b0, 6, 1'b1, "R7");
        xfer(1'b0, 8'd0,   4'd2,  1'b1, 4, 1'b1, "R7");
        // stop after an odd count, then restart at once
        xfer(1'b1, 8'd1,   4'd0,  1'b0, 3, 1'b0, "R8");
        xfer(1'b1, 8'd1,   4'd0,  1'b0, 2, 1'b0, "R8");
        bypass_run(1'b0);
        bypass_run(1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule